// File: doc/BRIEF.md
# Memory Ordering Request Encoder

This block sits between the address-generation stage and a memory port. Each cycle it may take one request made of an address, an access size, an access class, and three ordering flags: acquire, release, and reserved/conditional. From these it produces one of two results. The first is a four-bit operation kind that the memory port acts on. The second is an architectural exception code when the request cannot be issued. Write requests that carry release or conditional semantics must be naturally aligned. Some flag combinations have no legal meaning and are refused.

The result is registered. A small state machine holds the class of the response now presented. ST_IDLE means no response. ST_ISSUE means a valid operation kind. ST_FAULT means a valid exception code. Every state moves on each clock edge:

- to ST_IDLE when no request is offered;
- to ST_ISSUE when the request encodes cleanly;
- to ST_FAULT when it is refused.

The payload registers load in the same edge, so a response follows its request by exactly one cycle. Back-to-back requests are accepted every cycle.

Top module: `mo_req_encoder`

## Requirements
- R1: After reset all outputs are 0. `rsp_valid_o` in a cycle equals `req_valid_i` sampled at the preceding rising clock edge, so there is exactly one cycle of latency.
- R2: For a write (access class 1) that is accepted, the flags map to these kinds:
  - no flag: 8
  - release only: 9
  - acquire+release: 10
  - conditional only: 11
  - conditional+release: 12
  - conditional+acquire+release: 13
- R3: A write with acquire set and release clear is refused with exception code 2, whatever the conditional flag says, unless R4 applies.
- R4: A write with release or conditional set is refused with exception code 6 when the address is not a multiple of the access size. This check takes precedence over R3. The size code s gives 2^s bytes.
- R5: A write with both release and conditional clear is not alignment-checked, so a misaligned plain write or acquire-only write follows R2 or R3.
- R6: For a read (class 0), an AMO (class 2) or an execute (class 3) that is accepted, the flags map to these kinds:
  - no flag: 0
  - acquire: 1
  - acquire+release: 2
  - reserved: 3
  - reserved+acquire: 4
  - reserved+acquire+release: 5
- R7: A non-write request with release set and acquire clear, with or without the reserved flag, is refused. The exception code depends on the class:
  - execute: 1
  - read: 5
  - AMO: 7
- R8: Non-write requests are never alignment-checked.
- R9: When `rsp_err_o` is 1, `rsp_kind_o` is 0. When a valid response has `rsp_err_o` 0, `rsp_exc_o` is 0.
- R10: A cycle with no request gives `rsp_valid_o` 0 and `rsp_err_o` 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid_i | input | 1 | Request offered this cycle |
| req_addr_i | input | ADDR_W | Request address |
| req_size_i | input | 2 | Size code: 2^code bytes |
| req_acc_i | input | 2 | Access class: 0 read, 1 write, 2 AMO, 3 execute |
| req_aq_i | input | 1 | Acquire flag |
| req_rl_i | input | 1 | Release flag |
| req_rsv_i | input | 1 | Reserved (read) / conditional (write) flag |
| rsp_valid_o | output | 1 | Response present |
| rsp_err_o | output | 1 | Response is an exception |
| rsp_kind_o | output | 4 | Operation kind, valid when no error |
| rsp_exc_o | output | 4 | Exception code, valid with error |

## Verification
The sweep covers all of these in every combination:

- the four access classes;
- all eight flag settings;
- all four sizes;
- every value of the three low address bits.

This combination tells an aligned address from a misaligned one at each size. It therefore separates the alignment fault from the unsupported-flag fault where both could apply, and it shows that plain writes and all reads ignore misalignment. The three non-write classes share their encodings but differ in the fault code, so repeating the read-side flags under each class shows which code each class receives. Idle cycles are placed between requests and after the sweep, to show that the valid and error outputs drop.

// File: rtl/mo_pkg.sv
`timescale 1ns/1ps
package mo_pkg;

    localparam int SIZE_W = 2;
    localparam int LOW_W  = (1 << SIZE_W) - 1;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_AMO   = 2'd2,
        ACC_EXEC  = 2'd3
    } acc_e;

    typedef enum logic [3:0] {
        OP_RD_PLAIN      = 4'd0,
        OP_RD_ACQ        = 4'd1,
        OP_RD_STRONG     = 4'd2,
        OP_RD_RSV        = 4'd3,
        OP_RD_RSV_ACQ    = 4'd4,
        OP_RD_RSV_STRONG = 4'd5,
        OP_WR_PLAIN      = 4'd8,
        OP_WR_REL        = 4'd9,
        OP_WR_STRONG_REL = 4'd10,
        OP_WR_COND       = 4'd11,
        OP_WR_COND_REL   = 4'd12,
        OP_WR_COND_STRONG= 4'd13
    } op_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_FAULT = 2'd2
    } rsp_state_e;

    localparam logic [3:0] EXC_NONE        = 4'd0;
    localparam logic [3:0] EXC_FETCH_ACC   = 4'd1;
    localparam logic [3:0] EXC_ILLEGAL     = 4'd2;
    localparam logic [3:0] EXC_LOAD_ACC    = 4'd5;
    localparam logic [3:0] EXC_ST_MISALIGN = 4'd6;
    localparam logic [3:0] EXC_ST_ACC      = 4'd7;

endpackage

// File: rtl/mo_align_chk.sv
`timescale 1ns/1ps
module mo_align_chk
    import mo_pkg::*;
(
    input  logic [LOW_W-1:0]  addr_lo_i,
    input  logic [SIZE_W-1:0] size_i,
    output logic              misaligned_o
);
    logic [LOW_W-1:0] hit;

    for (genvar i = 0; i < LOW_W; i++) begin : g_bit
        assign hit[i] = addr_lo_i[i] & (32'(size_i) > i);
    end

    assign misaligned_o = |hit;
endmodule

// File: rtl/mo_wr_encode.sv
`timescale 1ns/1ps
module mo_wr_encode
    import mo_pkg::*;
(
    input  logic       aq_i,
    input  logic       rl_i,
    input  logic       cond_i,
    input  logic       misaligned_i,
    output logic       ok_o,
    output op_kind_e   kind_o,
    output logic [3:0] exc_o
);
    always_comb begin
        ok_o   = 1'b1;
        kind_o = OP_WR_PLAIN;
        exc_o  = EXC_NONE;
        if ((rl_i | cond_i) & misaligned_i) begin
            ok_o  = 1'b0;
            exc_o = EXC_ST_MISALIGN;
        end else begin
            unique case ({aq_i, rl_i, cond_i})
                3'b000: kind_o = OP_WR_PLAIN;
                3'b010: kind_o = OP_WR_REL;
                3'b001: kind_o = OP_WR_COND;
                3'b011: kind_o = OP_WR_COND_REL;
                3'b110: kind_o = OP_WR_STRONG_REL;
                3'b111: kind_o = OP_WR_COND_STRONG;
                default: begin
                    ok_o  = 1'b0;
                    exc_o = EXC_ILLEGAL;
                end
            endcase
        end
    end
endmodule

// File: rtl/mo_rd_encode.sv
`timescale 1ns/1ps
module mo_rd_encode
    import mo_pkg::*;
(
    input  logic [1:0] acc_i,
    input  logic       aq_i,
    input  logic       rl_i,
    input  logic       rsv_i,
    output logic       ok_o,
    output op_kind_e   kind_o,
    output logic [3:0] exc_o
);
    logic [3:0] fault_code;

    always_comb begin
        unique case (acc_i)
            ACC_EXEC: fault_code = EXC_FETCH_ACC;
            ACC_READ: fault_code = EXC_LOAD_ACC;
            default:  fault_code = EXC_ST_ACC;
        endcase
    end

    always_comb begin
        ok_o   = 1'b1;
        kind_o = OP_RD_PLAIN;
        exc_o  = EXC_NONE;
        unique case ({aq_i, rl_i, rsv_i})
            3'b000: kind_o = OP_RD_PLAIN;
            3'b100: kind_o = OP_RD_ACQ;
            3'b110: kind_o = OP_RD_STRONG;
            3'b001: kind_o = OP_RD_RSV;
            3'b101: kind_o = OP_RD_RSV_ACQ;
            3'b111: kind_o = OP_RD_RSV_STRONG;
            default: begin
                ok_o  = 1'b0;
                exc_o = fault_code;
            end
        endcase
    end
endmodule

// File: rtl/mo_req_encoder.sv
`timescale 1ns/1ps
module mo_req_encoder
    import mo_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [1:0]        req_size_i,
    input  logic [1:0]        req_acc_i,
    input  logic              req_aq_i,
    input  logic              req_rl_i,
    input  logic              req_rsv_i,
    output logic              rsp_valid_o,
    output logic              rsp_err_o,
    output logic [3:0]        rsp_kind_o,
    output logic [3:0]        rsp_exc_o
);
    logic addr_unused_hi;
    assign addr_unused_hi = ^req_addr_i[ADDR_W-1:LOW_W];

    logic       misaligned;
    logic       is_write;
    logic       wr_ok, rd_ok, sel_ok;
    op_kind_e   wr_kind, rd_kind, sel_kind;
    logic [3:0] wr_exc, rd_exc, sel_exc;

    rsp_state_e state_q, state_d;
    op_kind_e   kind_q;
    logic [3:0] exc_q;

    assign is_write = (req_acc_i == ACC_WRITE);

    mo_align_chk u_align (
        .addr_lo_i    (req_addr_i[LOW_W-1:0]),
        .size_i       (req_size_i),
        .misaligned_o (misaligned)
    );

    mo_wr_encode u_wr (
        .aq_i         (req_aq_i),
        .rl_i         (req_rl_i),
        .cond_i       (req_rsv_i),
        .misaligned_i (misaligned),
        .ok_o         (wr_ok),
        .kind_o       (wr_kind),
        .exc_o        (wr_exc)
    );

    mo_rd_encode u_rd (
        .acc_i  (req_acc_i),
        .aq_i   (req_aq_i),
        .rl_i   (req_rl_i),
        .rsv_i  (req_rsv_i),
        .ok_o   (rd_ok),
        .kind_o (rd_kind),
        .exc_o  (rd_exc)
    );

    assign sel_ok   = is_write ? wr_ok   : rd_ok;
    assign sel_kind = is_write ? wr_kind : rd_kind;
    assign sel_exc  = is_write ? wr_exc  : rd_exc;

    // next-state: every state reacts to the offered request alone
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_ISSUE, ST_FAULT: begin
                if (!req_valid_i)  state_d = ST_IDLE;
                else if (sel_ok)   state_d = ST_ISSUE;
                else               state_d = ST_FAULT;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            kind_q  <= OP_RD_PLAIN;
            exc_q   <= EXC_NONE;
        end else begin
            state_q <= state_d;
            kind_q  <= (req_valid_i && sel_ok) ? sel_kind : OP_RD_PLAIN;
            exc_q   <= (req_valid_i && !sel_ok) ? sel_exc : EXC_NONE;
        end
    end

    // outputs decoded from the held state
    always_comb begin
        rsp_valid_o = 1'b0;
        rsp_err_o   = 1'b0;
        rsp_kind_o  = 4'd0;
        rsp_exc_o   = EXC_NONE;
        unique case (state_q)
            ST_IDLE: ;
            ST_ISSUE: begin
                rsp_valid_o = 1'b1;
                rsp_kind_o  = kind_q;
            end
            ST_FAULT: begin
                rsp_valid_o = 1'b1;
                rsp_err_o   = 1'b1;
                rsp_exc_o   = exc_q;
            end
            default: ;
        endcase
    end

    assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_i |=> rsp_valid_o);

    assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid_i |=> (!rsp_valid_o && !rsp_err_o));

    assert_misalign_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && is_write && (req_rl_i || req_rsv_i) && misaligned)
        |=> (rsp_err_o && rsp_exc_o == EXC_ST_MISALIGN));

    assert_unsup_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && is_write && req_aq_i && !req_rl_i && !(req_rsv_i && misaligned))
        |=> (rsp_err_o && rsp_exc_o == EXC_ILLEGAL));

    assert_wr_kind_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && is_write && wr_ok) |=> (!rsp_err_o && rsp_kind_o[3]));

    assert_rd_fail_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && !is_write && req_rl_i && !req_aq_i) |=> rsp_err_o);

    assert_fields_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_err_o |-> rsp_kind_o == 4'd0) and
        ((rsp_valid_o && !rsp_err_o) |-> rsp_exc_o == EXC_NONE));

endmodule

// File: tb/mo_req_encoder_tb.sv
`timescale 1ns/1ps
module mo_req_encoder_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [31:0] req_addr;
    logic [1:0]  req_size, req_acc;
    logic        req_aq, req_rl, req_rsv;
    logic        rsp_valid, rsp_err;
    logic [3:0]  rsp_kind, rsp_exc;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    mo_req_encoder #(.ADDR_W(32)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid_i(req_valid), .req_addr_i(req_addr),
        .req_size_i(req_size), .req_acc_i(req_acc),
        .req_aq_i(req_aq), .req_rl_i(req_rl), .req_rsv_i(req_rsv),
        .rsp_valid_o(rsp_valid), .rsp_err_o(rsp_err),
        .rsp_kind_o(rsp_kind), .rsp_exc_o(rsp_exc)
    );

    task automatic check(input string tag, input logic [9:0] act, input logic [9:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got valid/err/kind/exc=%b expected %b", tag, act, exp);
        end
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_size = '0;
        req_acc = '0; req_aq = 1'b0; req_rl = 1'b0; req_rsv = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 reset", {rsp_valid, rsp_err, rsp_kind, rsp_exc}, 10'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 idle after reset", {rsp_valid, rsp_err, rsp_kind, rsp_exc}, 10'b0);

        for (int acc = 0; acc < 4; acc++) begin
            for (int fl = 0; fl < 8; fl++) begin
                for (int sz = 0; sz < 4; sz++) begin
                    for (int lo = 0; lo < 8; lo++) begin
                        logic aq, rl, c, mis, e;
                        logic [3:0] k, x;
                        string tag;
                        aq = fl[2]; rl = fl[1]; c = fl[0];
                        mis = (lo % (1 << sz)) != 0;
                        e = 1'b0; k = 4'd0; x = 4'd0;
                        if (acc == 1) begin
                            if ((rl || c) && mis) begin
                                e = 1'b1; x = 4'd6; tag = "R4 write misaligned";
                            end else if (aq && !rl) begin
                                e = 1'b1; x = 4'd2; tag = "R3 write unsupported";
                            end else begin
                                k = 4'(8 + (c ? 3 : 0) + (aq ? 2 : (rl ? 1 : 0)));
                                tag = mis ? "R5 plain write unchecked" : "R2 write kind";
                            end
                        end else begin
                            if (rl && !aq) begin
                                e = 1'b1;
                                x = (acc == 3) ? 4'd1 : (acc == 0) ? 4'd5 : 4'd7;
                                tag = "R7 read fault";
                            end else begin
                                k = 4'((c ? 3 : 0) + (aq ? (rl ? 2 : 1) : 0));
                                tag = mis ? "R8 read unchecked" : "R6 read kind";
                            end
                        end
                        req_valid = 1'b1;
                        req_acc = 2'(acc); req_aq = aq; req_rl = rl; req_rsv = c;
                        req_size = 2'(sz);
                        req_addr = 32'h4000_0100 | 32'(lo);
                        @(posedge clk);
                        #1;
                        // R1 valid one cycle later; R9 unused field zero
                        check(tag, {rsp_valid, rsp_err, rsp_kind, rsp_exc}, {1'b1, e, k, x});
                        @(negedge clk);
                    end
                end
                // R10: gap with no request
                req_valid = 1'b0;
                req_rl = 1'b1; req_rsv = 1'b1;
                @(posedge clk);
                #1;
                check("R10 gap", {rsp_valid, rsp_err, rsp_kind, rsp_exc}, 10'b0);
                @(negedge clk);
            end
        end
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule